// File: doc/BRIEF.md
# Address-Encoded Control Register Bank

This block is a byte-wide bank of control registers for a network adapter. Software issues one access on a synchronous valid/write port. The address carries three fields: the register index, the operation and the area. Because the operation sits in the address, one bus cycle can set or clear bits atomically, and the host needs no read-modify-write sequence.

The control area holds eighteen byte registers in even/odd pairs. Among them are a shared-RAM relocation pair, a host interrupt-status pair and a timer pair. The odd relocation register is read-only and reports a strapped shared-RAM size. The even host status register does three jobs: it collects timer, internal-error and access-error events, it gates the interrupt outputs, and it steers them to either the normal interrupt line or the channel-check line. Two identification areas return constant data. A reserved area, the undefined registers and any attempt to modify read-only locations raise the access-error flag.

Top module: `acr_bank`

## Requirements
- R1: `req_addr` is split into fields. Bits 4:0 are the register index, bits 6:5 the operation (00 write, 01 AND, 10 OR, 11 read) and bits 8:7 the area (00 control, 01 reserved, 10 identification A, 11 identification B). In the control area, indices 0x00–0x11 are defined and 0x12–0x1F are undefined.
- R2: A write to a defined, writable control register replaces its value at the clock edge that samples the request. A read issued in the next cycle returns the new value.
- R3: An AND access leaves register & data in the register, with the same one-edge latency as a write.
- R4: An OR access leaves register | data in the register, with the same one-edge latency as a write.
- R5: Every read (op 11) gives `rsp_valid` high for exactly the cycle after the request, with the data on `rsp_rdata`. Other accesses and idle cycles give no `rsp_valid`.
- R6: Register 0x01 always reads {4'b0, ram_size_strap, 2'b00}, so the size code sits in bits 3:2 (00=8 KB, 01=16 KB, 10=32 KB, 11=64 KB). Write, AND and OR accesses to it change nothing.
- R7: `ram_base` equals bits 7:1 of register 0x00. These are shared-RAM address bits 19:13.
- R8: Some accesses set bit 2 of register 0x08 one edge after the request. These are: any access to the reserved area, any access to an undefined register, a write/AND/OR to register 0x01, and a write/AND/OR to an identification area. Reads of the reserved area or of undefined registers return 0x00.
- R9: Identification area A, byte i, reads {4'h0, nibble i of NODE_ADDR counted from the most significant nibble} for i < 12, and reads 0x00 otherwise. Modify accesses do not change it.
- R10: Identification area B, byte i, reads {i[4:0], 3'b000} ^ 8'hA5.
- R11: `hw_timer_exp` sets bit 4 and `hw_int_err` sets bit 3 of register 0x08 one edge later. In the same cycle, a set from hardware wins over a host write or AND that would clear the bit.
- R12: Let pending = reg08[6] & |reg08[4:2]. Then `irq_out` = pending & reg08[7], `chk_out` = pending & ~reg08[7] and `alt_sel` = reg08[0]. All registers reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 9 | Area, operation and register index |
| req_wdata | input | 8 | Operand byte for write/AND/OR |
| ram_size_strap | input | 2 | Strapped shared-RAM size code |
| hw_timer_exp | input | 1 | Timer expiry event |
| hw_int_err | input | 1 | Internal error event |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| ram_base | output | 7 | Shared-RAM base address bits 19:13 |
| irq_out | output | 1 | Normal interrupt line |
| chk_out | output | 1 | Channel-check line |
| alt_sel | output | 1 | Primary (0) / alternate (1) adapter flag |

## Verification
Each request is driven on a falling edge and captured on the next rising edge. Register updates, status-bit sets and the interrupt outputs therefore settle one rising edge after the request, and the output pins are sampled on the falling edge that follows. Read data is also due one rising edge after the read: the driver queues the expected byte when it issues the read, and the monitor pops the queue on every falling edge where `rsp_valid` is high. A late, missing or extra response therefore shows up as a mismatch, an unexpected response or a leftover entry.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int DATA_W     = 8;
    localparam int IDX_W      = 5;
    localparam int OP_W       = 2;
    localparam int AREA_W     = 2;
    localparam int ADDR_W     = AREA_W + OP_W + IDX_W;
    localparam int NODE_W     = 48;
    localparam int NODE_NIBS  = NODE_W / 4;
    localparam int SIZE_W     = 2;

    // register indices the logic depends on
    localparam int REG_RELOC_EVEN = 0;
    localparam int REG_RELOC_ODD  = 1;
    localparam int REG_HSTAT      = 8;

    // host status bit positions
    localparam int HS_ALT = 0;
    localparam int HS_ACC = 2;
    localparam int HS_ERR = 3;
    localparam int HS_TMR = 4;
    localparam int HS_EN  = 6;
    localparam int HS_SEL = 7;

    typedef enum logic [OP_W-1:0] {
        OP_WRITE = 2'b00,
        OP_AND   = 2'b01,
        OP_OR    = 2'b10,
        OP_READ  = 2'b11
    } acc_op_e;

    typedef enum logic [AREA_W-1:0] {
        AR_CTRL = 2'b00,
        AR_RSVD = 2'b01,
        AR_IDA  = 2'b10,
        AR_IDB  = 2'b11
    } area_e;

    // address layout, most significant field first
    typedef struct packed {
        area_e              area;
        acc_op_e            op;
        logic [IDX_W-1:0]   idx;
    } acc_addr_t;

    typedef struct packed {
        logic               active;
        logic               modify;
        logic               ctrl_hit;
        logic               err;
        acc_op_e            op;
        area_e              area;
        logic [IDX_W-1:0]   idx;
    } acc_cmd_t;

    function automatic logic [DATA_W-1:0] merge_byte(
        input acc_op_e           op,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wd
    );
        logic [DATA_W-1:0] res;
        case (op)
            OP_WRITE: res = wd;
            OP_AND:   res = cur & wd;
            OP_OR:    res = cur | wd;
            default:  res = cur;
        endcase
        return res;
    endfunction

    function automatic logic [DATA_W-1:0] id_a_byte(
        input logic [NODE_W-1:0] node,
        input logic [IDX_W-1:0]  i
    );
        logic [NODE_W-1:0] sh;
        logic [DATA_W-1:0] res;
        res = '0;
        if (int'(i) < NODE_NIBS) begin
            sh  = node >> (NODE_W - 4 - 4 * int'(i));
            res = {4'h0, sh[3:0]};
        end
        return res;
    endfunction

    function automatic logic [DATA_W-1:0] id_b_byte(input logic [IDX_W-1:0] i);
        return {i, 3'b000} ^ 8'hA5;
    endfunction

endpackage

// File: rtl/acr_decode.sv
module acr_decode
    import acr_pkg::*;
#(
    parameter int REG_COUNT = 18
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_cmd_t          cmd
);

    localparam logic [IDX_W:0] CNT_LIM = (IDX_W+1)'(REG_COUNT);
    localparam logic [IDX_W-1:0] RO_IDX = IDX_W'(REG_RELOC_ODD);

    acc_addr_t a;
    logic      in_range;
    logic      is_ro;
    logic      is_mod;
    logic      bad;

    always_comb begin
        a        = acc_addr_t'(req_addr);
        in_range = ({1'b0, a.idx} < CNT_LIM);
        is_ro    = (a.idx == RO_IDX);
        is_mod   = (a.op != OP_READ);
        case (a.area)
            AR_CTRL: bad = !in_range || (is_mod && is_ro);
            AR_RSVD: bad = 1'b1;
            default: bad = is_mod;
        endcase

        cmd.active   = req_valid;
        cmd.modify   = req_valid && is_mod;
        cmd.ctrl_hit = (a.area == AR_CTRL) && in_range && !is_ro;
        cmd.err      = req_valid && bad;
        cmd.op       = a.op;
        cmd.area     = a.area;
        cmd.idx      = a.idx;
    end

endmodule

// File: rtl/acr_regfile.sv
module acr_regfile
    import acr_pkg::*;
#(
    parameter int REG_COUNT = 18
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              mod_en,
    input  logic                              ctrl_hit,
    input  logic                              acc_err,
    input  acc_op_e                           op,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic [SIZE_W-1:0]                 size_strap,
    input  logic                              hw_tmr,
    input  logic                              hw_err,
    output logic [REG_COUNT-1:0][DATA_W-1:0]  reg_q
);

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        if (i == REG_RELOC_ODD) begin : g_ro
            // read-only size report, nothing stored
            assign reg_q[i] = {4'b0000, size_strap, 2'b00};
        end else begin : g_rw
            logic [DATA_W-1:0] set_mask;
            logic [DATA_W-1:0] nxt;
            logic              hit;

            if (i == REG_HSTAT) begin : g_hs
                always_comb begin
                    set_mask         = '0;
                    set_mask[HS_TMR] = hw_tmr;
                    set_mask[HS_ERR] = hw_err;
                    set_mask[HS_ACC] = acc_err;
                end
            end else begin : g_plain
                assign set_mask = '0;
            end

            assign hit = mod_en && ctrl_hit && (idx == IDX_W'(i));

            always_comb begin
                nxt = reg_q[i];
                if (hit)
                    nxt = merge_byte(op, reg_q[i], wdata);
                // hardware and error sets override a same-cycle clear
                nxt = nxt | set_mask;
            end

            always_ff @(posedge clk) begin
                if (rst)
                    reg_q[i] <= '0;
                else
                    reg_q[i] <= nxt;
            end
        end
    end

endmodule

// File: rtl/acr_rdmux.sv
module acr_rdmux
    import acr_pkg::*;
#(
    parameter int                REG_COUNT = 18,
    parameter logic [NODE_W-1:0] NODE_ADDR = 48'h4000_1234_ABCD
) (
    input  logic [REG_COUNT-1:0][DATA_W-1:0] reg_q,
    input  area_e                            area,
    input  logic [IDX_W-1:0]                 idx,
    output logic [DATA_W-1:0]                rdata
);

    localparam logic [IDX_W:0] CNT_LIM = (IDX_W+1)'(REG_COUNT);

    always_comb begin
        rdata = '0;
        case (area)
            AR_CTRL: if ({1'b0, idx} < CNT_LIM) rdata = reg_q[idx];
            AR_IDA:  rdata = id_a_byte(NODE_ADDR, idx);
            AR_IDB:  rdata = id_b_byte(idx);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/acr_bank.sv
module acr_bank
    import acr_pkg::*;
#(
    parameter int                REG_COUNT = 18,
    parameter logic [NODE_W-1:0] NODE_ADDR = 48'h4000_1234_ABCD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SIZE_W-1:0] ram_size_strap,
    input  logic              hw_timer_exp,
    input  logic              hw_int_err,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [6:0]        ram_base,
    output logic              irq_out,
    output logic              chk_out,
    output logic              alt_sel
);

    acc_cmd_t                          cmd;
    logic [REG_COUNT-1:0][DATA_W-1:0]  reg_q;
    logic [DATA_W-1:0]                 rd_mux;
    logic [DATA_W-1:0]                 hstat;
    logic                              pending;
    logic                              is_read;

    acr_decode #(.REG_COUNT(REG_COUNT)) u_dec (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .cmd       (cmd)
    );

    acr_regfile #(.REG_COUNT(REG_COUNT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .mod_en     (cmd.modify),
        .ctrl_hit   (cmd.ctrl_hit),
        .acc_err    (cmd.err),
        .op         (cmd.op),
        .idx        (cmd.idx),
        .wdata      (req_wdata),
        .size_strap (ram_size_strap),
        .hw_tmr     (hw_timer_exp),
        .hw_err     (hw_int_err),
        .reg_q      (reg_q)
    );

    acr_rdmux #(.REG_COUNT(REG_COUNT), .NODE_ADDR(NODE_ADDR)) u_rd (
        .reg_q (reg_q),
        .area  (cmd.area),
        .idx   (cmd.idx),
        .rdata (rd_mux)
    );

    assign is_read = cmd.active && (cmd.op == OP_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= is_read;
            if (is_read)
                rsp_rdata <= rd_mux;
        end
    end

    assign hstat    = reg_q[REG_HSTAT];
    assign ram_base = reg_q[REG_RELOC_EVEN][7:1];
    assign pending  = hstat[HS_EN] && (hstat[HS_TMR] || hstat[HS_ERR] || hstat[HS_ACC]);
    assign irq_out  = pending && hstat[HS_SEL];
    assign chk_out  = pending && !hstat[HS_SEL];
    assign alt_sel  = hstat[HS_ALT];

endmodule

// File: rtl/acr_bank_chk.sv
module acr_bank_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] addr_op,
    input logic [1:0] addr_area,
    input logic       hw_timer_exp,
    input logic       hw_int_err,
    input logic       rsp_valid,
    input logic       irq_out,
    input logic       chk_out,
    input logic [7:0] hstat
);

    assert_read_rsp_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && addr_op == 2'b11) |=> rsp_valid);

    assert_no_extra_rsp_R5: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && addr_op == 2'b11) |=> !rsp_valid);

    assert_timer_set_R11: assert property (@(posedge clk) disable iff (rst)
        hw_timer_exp |=> hstat[4]);

    assert_err_set_R11: assert property (@(posedge clk) disable iff (rst)
        hw_int_err |=> hstat[3]);

    assert_rsvd_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && addr_area == 2'b01) |=> hstat[2]);

    assert_gate_off_R12: assert property (@(posedge clk) disable iff (rst)
        !hstat[6] |-> (!irq_out && !chk_out));

endmodule

bind acr_bank acr_bank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .addr_op      (req_addr[6:5]),
    .addr_area    (req_addr[8:7]),
    .hw_timer_exp (hw_timer_exp),
    .hw_int_err   (hw_int_err),
    .rsp_valid    (rsp_valid),
    .irq_out      (irq_out),
    .chk_out      (chk_out),
    .hstat        (hstat)
);

// File: tb/tb_acr_bank.sv
`timescale 1ns/1ps
module tb_acr_bank;

    localparam logic [47:0] NODE = 48'h4000_1234_ABCD;
    localparam int NREG = 18;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [8:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [1:0] ram_size_strap = 2'b10;
    logic       hw_timer_exp = 1'b0;
    logic       hw_int_err = 1'b0;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic [6:0] ram_base;
    logic       irq_out, chk_out, alt_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] mdl [NREG];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    acr_bank dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .ram_size_strap(ram_size_strap),
        .hw_timer_exp(hw_timer_exp), .hw_int_err(hw_int_err),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_base(ram_base),
        .irq_out(irq_out), .chk_out(chk_out), .alt_sel(alt_sel)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] area, input logic [4:0] idx);
        logic [47:0] sh;
        case (area)
            2'b00: begin
                if (idx == 5'd1) return {4'b0, ram_size_strap, 2'b00};
                if (int'(idx) < NREG) return mdl[idx];
                return 8'h00;
            end
            2'b10: begin
                if (int'(idx) < 12) begin
                    sh = NODE >> (44 - 4 * int'(idx));
                    return {4'h0, sh[3:0]};
                end
                return 8'h00;
            end
            2'b11: return {idx, 3'b000} ^ 8'hA5;
            default: return 8'h00;
        endcase
    endfunction

    // driver: one access per cycle, expected read data queued at issue
    task automatic access(input logic [1:0] area, input logic [1:0] op, input logic [4:0] idx,
                          input logic [7:0] wd, input logic ht, input logic he, input string tag);
        logic err;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = {area, op, idx};
        req_wdata = wd;
        hw_timer_exp = ht;
        hw_int_err = he;
        err = (area == 2'b01) ||
              (area == 2'b00 && (int'(idx) >= NREG || (idx == 5'd1 && op != 2'b11))) ||
              (area[1] && op != 2'b11);
        if (op == 2'b11) begin
            exp_q.push_back(exp_read(area, idx));
            tag_q.push_back(tag);
        end else if (area == 2'b00 && int'(idx) < NREG && idx != 5'd1) begin
            case (op)
                2'b00: mdl[idx] = wd;
                2'b01: mdl[idx] = mdl[idx] & wd;
                default: mdl[idx] = mdl[idx] | wd;
            endcase
        end
        mdl[8] = mdl[8] | {3'b000, ht, he, err, 2'b00};
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        hw_timer_exp = 1'b0;
        hw_int_err = 1'b0;
    endtask

    task automatic check_pins(input string tag);
        logic pend;
        idle();
        pend = mdl[8][6] && (|mdl[8][4:2]);
        check(irq_out == (pend && mdl[8][7]), tag, {7'b0, irq_out}, {7'b0, pend && mdl[8][7]});
        check(chk_out == (pend && !mdl[8][7]), tag, {7'b0, chk_out}, {7'b0, pend && !mdl[8][7]});
        check(alt_sel == mdl[8][0], tag, {7'b0, alt_sel}, {7'b0, mdl[8][0]});
        check(ram_base == mdl[0][7:1], "R7", {1'b0, ram_base}, {1'b0, mdl[0][7:1]});
    endtask

    // monitor: scoreboard pop on every response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected response", rsp_rdata, 8'h00);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_rdata == e, t, rsp_rdata, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state R12
        check(rsp_valid == 1'b0, "R5 reset", {7'b0, rsp_valid}, 8'h00);
        check_pins("R12 reset");

        // R2 / R7 relocation write then read
        access(2'b00, 2'b00, 5'd0, 8'hA6, 0, 0, "R2 write");
        access(2'b00, 2'b11, 5'd0, 8'h00, 0, 0, "R2 readback");
        check_pins("R7 base");

        // R3 / R4 AND and OR on timer control
        access(2'b00, 2'b00, 5'h0C, 8'hF0, 0, 0, "R2");
        access(2'b00, 2'b01, 5'h0C, 8'h3C, 0, 0, "R3");
        access(2'b00, 2'b11, 5'h0C, 8'h00, 0, 0, "R3 and result");
        access(2'b00, 2'b10, 5'h0C, 8'h05, 0, 0, "R4");
        access(2'b00, 2'b11, 5'h0C, 8'h00, 0, 0, "R4 or result");
        access(2'b00, 2'b00, 5'h11, 8'h9C, 0, 0, "R1 last defined");
        access(2'b00, 2'b11, 5'h11, 8'h00, 0, 0, "R1 last defined read");

        // R6 read-only size register
        access(2'b00, 2'b11, 5'd1, 8'h00, 0, 0, "R6 size read");
        access(2'b00, 2'b00, 5'd1, 8'hFF, 0, 0, "R6 write");
        access(2'b00, 2'b11, 5'd1, 8'h00, 0, 0, "R6 unchanged");
        access(2'b00, 2'b11, 5'd8, 8'h00, 0, 0, "R8 ro flag");
        idle();
        ram_size_strap = 2'b01;
        access(2'b00, 2'b11, 5'd1, 8'h00, 0, 0, "R6 strap 16k");

        // R8 / R12 reserved area raises irq
        access(2'b00, 2'b00, 5'd8, 8'hC0, 0, 0, "R12 enable");
        check_pins("R12 no pending");
        access(2'b01, 2'b11, 5'd3, 8'h00, 0, 0, "R8 reserved read");
        check_pins("R12 irq");
        access(2'b00, 2'b11, 5'd8, 8'h00, 0, 0, "R8 flag set");
        access(2'b00, 2'b01, 5'd8, 8'h7F, 0, 0, "R3 sel clear");
        check_pins("R12 chk");
        access(2'b00, 2'b00, 5'd8, 8'h41, 0, 0, "R12 alt");
        check_pins("R12 alt no pending");

        // R11 hardware set wins over host clear
        access(2'b00, 2'b01, 5'd8, 8'h00, 1, 0, "R11 timer vs and");
        access(2'b00, 2'b11, 5'd8, 8'h00, 0, 0, "R11 timer read");
        access(2'b00, 2'b00, 5'd8, 8'h40, 0, 1, "R11 err vs write");
        access(2'b00, 2'b11, 5'd8, 8'h00, 0, 0, "R11 err read");
        check_pins("R12 chk err");

        // R8 undefined register and ID modify
        access(2'b00, 2'b00, 5'd8, 8'h00, 0, 0, "R2 clear status");
        access(2'b00, 2'b11, 5'h15, 8'h00, 0, 0, "R8 undefined read");
        access(2'b00, 2'b11, 5'd8, 8'h00, 0, 0, "R8 undefined flag");
        access(2'b00, 2'b00, 5'd8, 8'h00, 0, 0, "R2 clear status");
        access(2'b10, 2'b00, 5'd2, 8'hFF, 0, 0, "R9 id write");
        access(2'b10, 2'b11, 5'd2, 8'h00, 0, 0, "R9 id unchanged");
        access(2'b00, 2'b11, 5'd8, 8'h00, 0, 0, "R8 id flag");

        // R9 / R10 identification areas, back-to-back reads (R5)
        for (int i = 0; i < 32; i++) access(2'b10, 2'b11, 5'(i), 8'h00, 0, 0, "R9 id A");
        for (int i = 0; i < 32; i++) access(2'b11, 2'b11, 5'(i), 8'h00, 0, 0, "R10 id B");
        idle();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 leftover", 8'(exp_q.size()), 8'h00);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule